// File: doc/BRIEF.md
# Dual-Channel Interval Timer

This block holds two independent 16-bit down-counters, called channel A (counter 0) and channel C (counter 2), both clocked by a shared fixed-rate tick enable. The nominal tick rate is 1,193,180 per second. A processor programs the block through a byte-wide register bus with four port selects. There is one data port for each channel and one control port.

A count is loaded as two byte writes, low byte first. The channel starts counting only once the high byte arrives. It then loses one per tick. When it reaches terminal count it reloads the programmed value, raises a status flag and pulses its interrupt.

A control-word latch command freezes a channel's count into a snapshot. The snapshot is then read out low byte first. With no snapshot held, reads alternate between the low and high bytes of the live count. Read-back commands and counting modes other than plain countdown are not supported. A control word that names an unsupported channel raises an error pulse.

Top module: `dual_interval_timer`

## Requirements
- R1: After a synchronous active-low reset, all counts, snapshots, byte pointers and pending-byte flags are cleared. `status0`, `status2`, `irq0`, `irq2` and `cmd_err` read 0, and reads of either channel return 0x00.
- R2: A data-port write with no byte pending stores a low byte and marks it pending, and leaves the count, reload value and counting state untouched. The next data-port write supplies the high byte. It loads {high, low} into both the count and the reload value, starts the channel and clears its status.
- R3: A running channel decrements by exactly one on each clock with `tick_en` high. Its count holds when `tick_en` is low or the channel has never been loaded.
- R4: A tick that arrives while the count is 1 reloads the programmed value and sets the status byte to 0x20 (bit 5). The status stays set until the next high-byte load. A loaded value of 0 runs for 65536 ticks.
- R5: `irq0` or `irq2` is high for one clock, the clock after each terminal tick of that channel. While it is high, the same channel's status bit 5 is set.
- R6: Control word bits 7:6 select the channel: 00 selects channel A and 10 selects channel C. The codes 01 and 11 change no state and pulse `cmd_err` high for the clock after the write.
- R7: Control bits 5:4 = 00 is a latch command. It copies the live count into the snapshot and points the read pointer at the low byte. Any other value in bits 5:4 is a setup write. A setup write discards a pending low byte, and bits 3:0 are ignored.
- R8: While a snapshot is held, reads return its low byte and then its high byte, and the high-byte read releases it. Ticks in the meantime leave the snapshot unchanged.
- R9: With no snapshot held, successive reads of a channel return the low byte and then the high byte of the live count, alternately. Each channel has its own pointer.
- R10: `bus_sel` encodes 0 as channel A data, 1 as channel C data, 2 as control and 3 as unused. Writes to 3 have no effect. Reads of 2 or 3 return 0x00 and move no pointer. `rd_data` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count tick, one clock wide per tick |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 2 | Port select (0 ch A data, 1 ch C data, 2 control, 3 unused) |
| bus_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid in the cycle of `bus_rd` |
| status0 | output | 8 | Channel A status (0x20 after terminal count) |
| status2 | output | 8 | Channel C status (0x20 after terminal count) |
| irq0 | output | 1 | Channel A terminal-count pulse |
| irq2 | output | 1 | Channel C terminal-count pulse |
| cmd_err | output | 1 | Unsupported control word pulse |

## Verification
`rd_data` is combinational. It answers in the same cycle as `bus_rd`, and the pointer advances at that cycle's closing edge. The bench therefore drives each operation just after a falling edge and samples `rd_data` 1 ns later, before the rising edge. Count, status, `irq0`, `irq2` and `cmd_err` change at the rising edge that ends the stimulus cycle. The bench compares them with its reference model at the next falling edge, which is one edge after the stimulus, so an interrupt that is late or that lasts two cycles shows up as a mismatch.

// File: rtl/pit_pkg.sv
// Package: shared constants and helpers for the dual interval timer.
// Assumes two bytes form a count and the status flag sits in bit 5.
package pit_pkg;
    localparam int TC_BIT = 5;

    typedef enum logic [1:0] {
        PORT_CHA  = 2'd0,
        PORT_CHC  = 2'd1,
        PORT_CTRL = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    // Control-word channel code of channel index idx (0 -> 00, 1 -> 10).
    function automatic logic [1:0] chan_code(input int idx);
        return 2'(idx * 2);
    endfunction
endpackage

// File: rtl/pit_cmd_decode.sv
// Module: decodes a control-port byte into per-channel latch and setup
// strobes, and flags channel codes that have no counter behind them.
// Assumes the channel field is the top two bits and the access field
// the two bits below it.
module pit_cmd_decode
    import pit_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_byte,
    output logic [NUM_CH-1:0] latch_stb,
    output logic [NUM_CH-1:0] setup_stb,
    output logic              cmd_err
);
    localparam int CH_HI  = BYTE_W - 1;
    localparam int ACC_HI = BYTE_W - 3;

    logic [1:0] chan_f;
    logic       latch_op;
    logic       bad_chan;

    assign chan_f   = ctrl_byte[CH_HI -: 2];
    assign latch_op = (ctrl_byte[ACC_HI -: 2] == 2'b00);
    assign bad_chan = chan_f[0];

    // Per-channel strobe generation.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        logic hit;
        assign hit          = ctrl_wr && (chan_f == chan_code(i));
        assign latch_stb[i] = hit && latch_op;
        assign setup_stb[i] = hit && !latch_op;
    end

    // Register the error pulse for one clock after a bad control word.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_err <= 1'b0;
        else        cmd_err <= ctrl_wr && bad_chan;
    end

    // R6
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(ctrl_wr) && ($past(latch_stb | setup_stb) == '0));

    // R7
    stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({latch_stb, setup_stb}));
endmodule

// File: rtl/pit_channel.sv
// Module: one countdown channel. It assembles the load value from two
// byte writes, counts down on tick_en, reloads at terminal count, and
// serves reads from a snapshot or from the live count.
// Assumes data_wr, data_rd, latch_stb and setup_stb are never high together.
module pit_channel
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic              latch_stb,
    input  logic              setup_stb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] status,
    output logic              irq
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0]  count_q, reload_q, snap_q, rd_src;
    logic [BYTE_W-1:0] lo_q;
    logic              lo_pend_q, run_q, held_q, rd_hi_q, tc_q, irq_q;
    logic              load_hi, at_term;

    assign load_hi = data_wr && lo_pend_q;
    assign at_term = tick_en && run_q && (count_q == ONE);

    // Count, reload value and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            run_q    <= 1'b0;
        end else if (load_hi) begin
            count_q  <= {wdata, lo_q};
            reload_q <= {wdata, lo_q};
            run_q    <= 1'b1;
        end else if (at_term) begin
            count_q <= reload_q;
        end else if (tick_en && run_q) begin
            count_q <= count_q - ONE;
        end
    end

    // Low-byte capture and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q      <= '0;
            lo_pend_q <= 1'b0;
        end else if (setup_stb) begin
            lo_pend_q <= 1'b0;
        end else if (data_wr) begin
            if (!lo_pend_q) lo_q <= wdata;
            lo_pend_q <= !lo_pend_q;
        end
    end

    // Terminal-count flag and one-clock interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= at_term && !load_hi;
            if (load_hi)      tc_q <= 1'b0;
            else if (at_term) tc_q <= 1'b1;
        end
    end

    // Snapshot, hold flag and read byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q  <= '0;
            held_q  <= 1'b0;
            rd_hi_q <= 1'b0;
        end else if (latch_stb) begin
            snap_q  <= count_q;
            held_q  <= 1'b1;
            rd_hi_q <= 1'b0;
        end else if (data_rd) begin
            rd_hi_q <= !rd_hi_q;
            if (held_q && rd_hi_q) held_q <= 1'b0;
        end
    end

    // Read byte selection.
    always_comb begin
        rd_src = held_q ? snap_q : count_q;
        if (!data_rd)     rdata = '0;
        else if (rd_hi_q) rdata = rd_src[CNT_W-1 -: BYTE_W];
        else              rdata = rd_src[BYTE_W-1:0];
    end

    assign status = tc_q ? BYTE_W'(1 << TC_BIT) : '0;
    assign irq    = irq_q;

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_hi) |=> $stable(count_q));

    // R4
    tc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_term && !load_hi) |=> (count_q == $past(reload_q)) && status[TC_BIT]);

    // R5
    irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status[TC_BIT]);

    // R2
    lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !lo_pend_q) |=> $stable(reload_q) && lo_pend_q);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && data_rd && rd_hi_q && !latch_stb) |=> !held_q);

    // R8
    snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !latch_stb) |=> $stable(snap_q));
endmodule

// File: rtl/dual_interval_timer.sv
// Module: top of the two-channel interval timer. It decodes the port
// select, routes strobes to the control decoder and both channels, and
// merges the read data.
// Assumes one bus operation per clock (bus_wr and bus_rd not both high).
module dual_interval_timer
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_sel,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] status0,
    output logic [BYTE_W-1:0] status2,
    output logic              irq0,
    output logic              irq2,
    output logic              cmd_err
);
    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0]              latch_stb, setup_stb, irq_v;
    logic [NUM_CH-1:0][BYTE_W-1:0]  rdata_v, status_v;

    pit_cmd_decode #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (bus_wr && (bus_sel == PORT_CTRL)),
        .ctrl_byte (bus_wdata),
        .latch_stb (latch_stb),
        .setup_stb (setup_stb),
        .cmd_err   (cmd_err)
    );

    // One channel per data port; channel i answers on port select i.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_me;
        assign sel_me = (bus_sel == 2'(i));
        pit_channel #(.BYTE_W(BYTE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_en   (tick_en),
            .data_wr   (bus_wr && sel_me),
            .data_rd   (bus_rd && sel_me),
            .latch_stb (latch_stb[i]),
            .setup_stb (setup_stb[i]),
            .wdata     (bus_wdata),
            .rdata     (rdata_v[i]),
            .status    (status_v[i]),
            .irq       (irq_v[i])
        );
    end

    // Merge read data; only the selected channel drives non-zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) rd_data = rd_data | rdata_v[i];
    end

    assign status0 = status_v[0];
    assign status2 = status_v[1];
    assign irq0    = irq_v[0];
    assign irq2    = irq_v[1];

    // R10
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_sel[1]) |-> (rd_data == '0));
endmodule

// File: tb/tb_dual_interval_timer.sv
`timescale 1ns/1ps
module tb_dual_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] rd_data, status0, status2;
    logic       irq0, irq2, cmd_err;

    int total = 0;
    int bad   = 0;

    // Reference model, one slot per channel.
    logic [15:0] m_cnt[2], m_rel[2], m_snap[2];
    logic [7:0]  m_lo[2];
    logic        m_pend[2], m_run[2], m_held[2], m_hi[2], m_tc[2], m_irq[2];
    logic        m_err;

    always #4 clk = ~clk;

    dual_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .status0(status0), .status2(status2),
        .irq0(irq0), .irq2(irq2), .cmd_err(cmd_err)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 0; m_rel[c] = 0; m_snap[c] = 0; m_lo[c] = 0;
            m_pend[c] = 0; m_run[c] = 0; m_held[c] = 0; m_hi[c] = 0;
            m_tc[c] = 0; m_irq[c] = 0;
        end
        m_err = 0;
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] s);
        logic [15:0] src;
        if (s[1]) return 8'h00;
        src = m_held[s] ? m_snap[s] : m_cnt[s];
        return m_hi[s] ? src[15:8] : src[7:0];
    endfunction

    task automatic model_step(input logic w, input logic r, input logic [1:0] s,
                              input logic [7:0] d, input logic t);
        m_err = w && (s == 2'd2) && d[6];
        for (int c = 0; c < 2; c++) begin
            logic dw, dr, lat, setup, hi_ld, term;
            dw    = w && (s == 2'(c));
            dr    = r && (s == 2'(c));
            lat   = w && (s == 2'd2) && (d[7:6] == 2'(c * 2)) && (d[5:4] == 2'b00);
            setup = w && (s == 2'd2) && (d[7:6] == 2'(c * 2)) && (d[5:4] != 2'b00);
            hi_ld = dw && m_pend[c];
            term  = t && m_run[c] && (m_cnt[c] == 16'd1);
            m_irq[c] = term && !hi_ld;
            if (lat) begin
                m_snap[c] = m_cnt[c]; m_held[c] = 1; m_hi[c] = 0;
            end else if (dr) begin
                if (m_held[c] && m_hi[c]) m_held[c] = 0;
                m_hi[c] = !m_hi[c];
            end
            if (hi_ld) begin
                m_cnt[c] = {d, m_lo[c]}; m_rel[c] = {d, m_lo[c]};
                m_run[c] = 1; m_tc[c] = 0;
            end else if (term) begin
                m_cnt[c] = m_rel[c]; m_tc[c] = 1;
            end else if (t && m_run[c]) begin
                m_cnt[c] = m_cnt[c] - 16'd1;
            end
            if (setup) m_pend[c] = 0;
            else if (dw) begin
                if (!m_pend[c]) m_lo[c] = d;
                m_pend[c] = !m_pend[c];
            end
        end
    endtask

    // One bus cycle: check registered outputs, drive, check read, advance model.
    task automatic cyc(input logic w, input logic r, input logic [1:0] s,
                       input logic [7:0] d, input logic t);
        logic [7:0] e;
        @(negedge clk);
        chk(status0 == (m_tc[0] ? 8'h20 : 8'h00), "R4 status0", status0, m_tc[0] ? 8'h20 : 8'h00);
        chk(status2 == (m_tc[1] ? 8'h20 : 8'h00), "R4 status2", status2, m_tc[1] ? 8'h20 : 8'h00);
        chk(irq0 == m_irq[0], "R5 irq0", irq0, m_irq[0]);
        chk(irq2 == m_irq[1], "R5 irq2", irq2, m_irq[1]);
        chk(cmd_err == m_err, "R6 cmd_err", cmd_err, m_err);
        bus_wr = w; bus_rd = r; bus_sel = s; bus_wdata = d; tick_en = t;
        #1;
        e = r ? exp_read(s) : 8'h00;
        chk(rd_data == e, r ? "R9 R8 R10 read" : "R10 idle rd_data", rd_data, e);
        @(posedge clk);
        model_step(w, r, s, d, t);
    endtask

    task automatic rd_word(input logic [1:0] s, input logic [15:0] exp16, input string req);
        logic [7:0] lo;
        cyc(0, 1, s, 8'h00, 0);
        @(negedge clk); lo = rd_data;
        bus_rd = 1; #1;
        chk({rd_data, lo} == exp16 || 1'b0 == 1'b1 ? 1'b1 : ({rd_data, lo} == exp16), req, {rd_data, lo}, exp16);
        bus_rd = 0;
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(200000 * 8);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state and zero reads of both channels
        chk(status0 == 8'h00 && status2 == 8'h00, "R1 status", status0, 0);
        chk(!irq0 && !irq2 && !cmd_err, "R1 pulses", {irq0, irq2, cmd_err}, 0);
        cyc(0, 1, 2'd0, 0, 0); cyc(0, 1, 2'd0, 0, 0); cyc(0, 1, 2'd1, 0, 0);
        // R2: low byte alone does not start channel A
        cyc(1, 0, 2'd0, 8'h03, 0);
        cyc(0, 0, 2'd0, 0, 1); cyc(0, 0, 2'd0, 0, 1);
        cyc(0, 1, 2'd0, 0, 0); cyc(0, 1, 2'd0, 0, 0);
        chk(m_cnt[0] == 16'd0, "R2 not started", m_cnt[0], 0);
        // R2 R3 R4 R5: high byte loads 3, three ticks reach terminal
        cyc(1, 0, 2'd0, 8'h00, 0);
        cyc(0, 0, 2'd0, 0, 1); cyc(0, 0, 2'd0, 0, 1); cyc(0, 0, 2'd0, 0, 1);
        cyc(0, 0, 2'd0, 0, 0); cyc(0, 0, 2'd0, 0, 0);
        cyc(0, 1, 2'd0, 0, 0); cyc(0, 1, 2'd0, 0, 0);
        // R7 R8: channel C 0x1234, latch, tick, read snapshot then live
        cyc(1, 0, 2'd1, 8'h34, 0); cyc(1, 0, 2'd1, 8'h12, 0);
        cyc(0, 0, 2'd1, 0, 1); cyc(0, 0, 2'd1, 0, 1);
        cyc(1, 0, 2'd2, 8'h80, 0);
        repeat (3) cyc(0, 0, 2'd1, 0, 1);
        cyc(0, 1, 2'd1, 0, 0); cyc(0, 1, 2'd1, 0, 0);
        cyc(0, 1, 2'd1, 0, 0); cyc(0, 1, 2'd1, 0, 0);
        // R6: unsupported channel codes
        cyc(1, 0, 2'd2, 8'h40, 0); cyc(1, 0, 2'd2, 8'hC0, 0); cyc(0, 0, 2'd0, 0, 0);
        // R10: unused port write and control reads change nothing visible
        cyc(1, 0, 2'd3, 8'hFF, 0); cyc(0, 1, 2'd2, 0, 0); cyc(0, 1, 2'd3, 0, 0);
        cyc(0, 1, 2'd1, 0, 0); cyc(0, 1, 2'd1, 0, 0);
        // R7: setup write discards a pending low byte
        cyc(1, 0, 2'd0, 8'hAA, 0); cyc(1, 0, 2'd2, 8'h36, 0);
        cyc(1, 0, 2'd0, 8'h05, 0); cyc(1, 0, 2'd0, 8'h00, 0);
        cyc(0, 1, 2'd0, 0, 0); cyc(0, 1, 2'd0, 0, 0);
        chk(m_rel[0] == 16'd5, "R7 setup discards low byte", m_rel[0], 5);
        // Random mix of writes, reads, latches and ticks
        for (int n = 0; n < 6000; n++) begin
            int op;
            logic [1:0] s;
            logic t;
            op = $urandom % 16;
            s  = 2'($urandom % 2);
            t  = ($urandom % 3) == 0;
            if (op < 2) begin
                rv = m_pend[s] ? (($urandom % 4 == 0) ? 8'($urandom) : 8'h00)
                               : 8'(1 + $urandom % 24);
                cyc(1, 0, s, rv, t);
            end else if (op < 3) begin
                rv = {s[0], 1'b0, 2'($urandom % 2) << 0, 4'($urandom)};
                if ($urandom % 4 == 0) rv[6] = 1'b1;
                cyc(1, 0, 2'd2, rv, t);
            end else if (op < 7) begin
                cyc(0, 1, 2'($urandom % 4), 0, t);
            end else begin
                cyc(0, 0, 2'd0, 0, t);
            end
        end
        cyc(0, 0, 2'd0, 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule